// File: doc/BRIEF.md
# Per-Line Snooping Coherence Controller with a Clean Exclusive State

This block holds the coherence state and tag of every line of a small direct-mapped cache and decides, for each processor access and each observed bus broadcast, what the line's next state is and what the cache must put on the shared bus. Each line is Invalid, Shared, Clean Exclusive or Dirty Exclusive. A read miss fills the line as Clean Exclusive when the bus reports that no other cache holds the block, and as Shared when it does. A later write to a Clean Exclusive line becomes Dirty Exclusive without any bus traffic.

Processor accesses and snoops resolve in one cycle. The bus request, the victim write-back strobe and the snoop flush strobe are combinational outputs in the cycle of the event, and the new line state is committed at the next rising clock edge. A snoop and a processor access in the same cycle are ordered so that the snoop acts first. Arbitration for the bus and the movement of data are left to the surrounding cache.

Top module: `cex_snoop_ctrl`

## Requirements
- R1: `line_st` reports the state of the line that `cpu_addr` selects when its stored tag matches, else 0, with the encoding 0 invalid, 1 shared, 2 clean exclusive, 3 dirty exclusive; after reset every line reads 0 and `cpu_hit` stays low.
- R2: The line index is the low log2(LINES) bits of an address and the tag is the rest; a processor read miss drives `bus_rd_miss` with `bus_addr` equal to `cpu_addr`, and the line becomes 2 when `fill_excl` is high in that cycle and 1 when it is low.
- R3: A processor read hit to a line in state 1, 2 or 3 raises `cpu_hit`, drives no bus request and leaves the state unchanged.
- R4: A processor write hit to a clean exclusive line drives no bus request and makes the line dirty exclusive (3).
- R5: A processor write hit to a shared line drives `bus_wr_miss` and makes the line 3.
- R6: A processor write miss from any state drives `bus_wr_miss` with `bus_addr` equal to `cpu_addr` and makes the line 3 under the new tag.
- R7: A miss that replaces a dirty exclusive line raises `evict_wb` in the cycle of its bus request with `evict_addr` equal to the victim's address; replacing a shared or clean exclusive line leaves `evict_wb` low.
- R8: A snooped read miss that matches a clean exclusive or dirty exclusive line moves it to shared (1); for a dirty line it also raises `flush_wb` in that cycle; a shared line stays shared.
- R9: A snooped write miss that matches a valid line invalidates it (0), and raises `flush_wb` when the line was dirty exclusive.
- R10: A snoop whose tag differs from the stored tag, or that selects an invalid line, changes no state and raises no `flush_wb`.
- R11: When a snoop and a processor access select the same line in one cycle, the snoop acts first and the access is judged against the state it leaves.
- R12: At most one of `bus_rd_miss` and `bus_wr_miss` is high in any cycle, and `evict_wb` is only high together with one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access valid |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | ADDR_W | Processor block address |
| fill_excl | input | 1 | No other cache holds the block being read |
| snp_rd | input | 1 | Another cache broadcasts a read miss |
| snp_wr | input | 1 | Another cache broadcasts a write miss |
| snp_addr | input | ADDR_W | Address of the broadcast |
| cpu_hit | output | 1 | Access hits a valid line |
| line_st | output | 2 | State of the addressed line (R1 encoding) |
| bus_rd_miss | output | 1 | Broadcast a read miss |
| bus_wr_miss | output | 1 | Broadcast a write miss |
| bus_addr | output | ADDR_W | Address of the broadcast request |
| evict_wb | output | 1 | Write back the dirty victim |
| evict_addr | output | ADDR_W | Address of the victim |
| flush_wb | output | 1 | Write back the dirty line hit by a snoop |

## Verification
The main function is driven with read misses under both fill answers, read and write hits in each valid state, and misses that replace invalid, shared, clean and dirty lines; comparing the bus request and write-back strobe across these tells a silent upgrade from an invalidating one and a clean victim from a dirty one. Snoops are applied to matching clean, dirty and shared lines and to a mismatching tag, so that the flush strobe and the following state reading separate a dirty downgrade from a clean one and from no effect. A snoop and a processor read to the same line in one cycle show whether the snoop is ordered first.

// File: rtl/cex_snoop_pkg.sv
package cex_snoop_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHD = 2'd1,
      LN_CLN = 2'd2,
      LN_DRT = 2'd3
   } line_st_e;

endpackage

// File: rtl/cex_line_store.sv
module cex_line_store
   import cex_snoop_pkg::*;
#(
   parameter int LINES = 8,
   parameter int TAG_W = 13,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] cpu_idx,
   input  logic             cpu_upd,
   input  line_st_e         cpu_nst,
   input  logic [TAG_W-1:0] cpu_ntag,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic             snp_upd,
   input  line_st_e         snp_nst,
   output line_st_e         cpu_cst,
   output logic [TAG_W-1:0] cpu_ctag,
   output line_st_e         snp_cst,
   output logic [TAG_W-1:0] snp_ctag
);

   line_st_e         st_vec  [LINES];
   logic [TAG_W-1:0] tag_vec [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_e         st_r;
      logic [TAG_W-1:0] tag_r;
      logic             cpu_sel;
      logic             snp_sel;

      assign cpu_sel = cpu_upd && (cpu_idx == IDX_W'(i));
      assign snp_sel = snp_upd && (snp_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r  <= LN_INV;
            tag_r <= '0;
         end else if (cpu_sel) begin
            st_r  <= cpu_nst;
            tag_r <= cpu_ntag;
         end else if (snp_sel) begin
            st_r  <= snp_nst;
         end
      end

      assign st_vec[i]  = st_r;
      assign tag_vec[i] = tag_r;
   end

   assign cpu_cst  = st_vec[cpu_idx];
   assign cpu_ctag = tag_vec[cpu_idx];
   assign snp_cst  = st_vec[snp_idx];
   assign snp_ctag = tag_vec[snp_idx];

endmodule

// File: rtl/cex_snoop_path.sv
module cex_snoop_path
   import cex_snoop_pkg::*;
#(
   parameter int TAG_W = 13
) (
   input  logic             snp_rd,
   input  logic             snp_wr,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_e         cur_st,
   input  logic [TAG_W-1:0] cur_tag,
   output logic             upd,
   output line_st_e         nxt_st,
   output logic             flush
);

   logic match;

   assign match = (cur_st != LN_INV) && (cur_tag == snp_tag);

   always_comb begin
      upd    = 1'b0;
      nxt_st = cur_st;
      flush  = 1'b0;
      if (match && snp_wr) begin
         upd    = 1'b1;
         nxt_st = LN_INV;
         flush  = (cur_st == LN_DRT);
      end else if (match && snp_rd) begin
         upd    = 1'b1;
         nxt_st = LN_SHD;
         flush  = (cur_st == LN_DRT);
      end
   end

endmodule

// File: rtl/cex_cpu_path.sv
module cex_cpu_path
   import cex_snoop_pkg::*;
#(
   parameter int TAG_W = 13
) (
   input  logic             req,
   input  logic             we,
   input  logic [TAG_W-1:0] tag,
   input  logic             fill_excl,
   input  line_st_e         cur_st,
   input  logic [TAG_W-1:0] cur_tag,
   output logic             hit,
   output line_st_e         seen_st,
   output logic             rd_miss,
   output logic             wr_miss,
   output logic             victim_dirty,
   output logic             upd,
   output line_st_e         nxt_st
);

   logic present;

   assign present = (cur_st != LN_INV) && (cur_tag == tag);
   assign seen_st = present ? cur_st : LN_INV;
   assign hit     = req && present;

   always_comb begin
      rd_miss      = 1'b0;
      wr_miss      = 1'b0;
      victim_dirty = 1'b0;
      upd          = 1'b0;
      nxt_st       = cur_st;
      if (req && !we) begin
         if (!present) begin
            rd_miss      = 1'b1;
            victim_dirty = (cur_st == LN_DRT);
            upd          = 1'b1;
            nxt_st       = fill_excl ? LN_CLN : LN_SHD;
         end
      end else if (req && we) begin
         upd    = 1'b1;
         nxt_st = LN_DRT;
         if (!present) begin
            wr_miss      = 1'b1;
            victim_dirty = (cur_st == LN_DRT);
         end else if (cur_st == LN_SHD) begin
            wr_miss = 1'b1;
         end
      end
   end

endmodule

// File: rtl/cex_snoop_ctrl.sv
module cex_snoop_ctrl
   import cex_snoop_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int ADDR_W = 16,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              fill_excl,
   input  logic              snp_rd,
   input  logic              snp_wr,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              cpu_hit,
   output logic [1:0]        line_st,
   output logic              bus_rd_miss,
   output logic              bus_wr_miss,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              evict_wb,
   output logic [ADDR_W-1:0] evict_addr,
   output logic              flush_wb
);

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0] c_idx, s_idx;
   logic [TAG_W-1:0] c_tag, s_tag;
   line_st_e         st_cpu_raw, st_snp_raw, snp_nst, cpu_base, cpu_nst, seen;
   logic [TAG_W-1:0] tag_cpu_raw, tag_snp_raw;
   logic             snp_upd, cpu_upd, victim_dirty, same_line;

   assign c_idx = cpu_addr[IDX_W-1:0];
   assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx = snp_addr[IDX_W-1:0];
   assign s_tag = snp_addr[ADDR_W-1:IDX_W];

   cex_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_idx  (c_idx),
      .cpu_upd  (cpu_upd),
      .cpu_nst  (cpu_nst),
      .cpu_ntag (c_tag),
      .snp_idx  (s_idx),
      .snp_upd  (snp_upd),
      .snp_nst  (snp_nst),
      .cpu_cst  (st_cpu_raw),
      .cpu_ctag (tag_cpu_raw),
      .snp_cst  (st_snp_raw),
      .snp_ctag (tag_snp_raw)
   );

   cex_snoop_path #(.TAG_W(TAG_W)) u_snoop (
      .snp_rd  (snp_rd),
      .snp_wr  (snp_wr),
      .snp_tag (s_tag),
      .cur_st  (st_snp_raw),
      .cur_tag (tag_snp_raw),
      .upd     (snp_upd),
      .nxt_st  (snp_nst),
      .flush   (flush_wb)
   );

   // Snoop is ordered ahead of a same-cycle access to the same line (R11).
   assign same_line = snp_upd && (s_idx == c_idx);
   assign cpu_base  = same_line ? snp_nst : st_cpu_raw;

   cex_cpu_path #(.TAG_W(TAG_W)) u_cpu (
      .req          (cpu_req),
      .we           (cpu_we),
      .tag          (c_tag),
      .fill_excl    (fill_excl),
      .cur_st       (cpu_base),
      .cur_tag      (tag_cpu_raw),
      .hit          (cpu_hit),
      .seen_st      (seen),
      .rd_miss      (bus_rd_miss),
      .wr_miss      (bus_wr_miss),
      .victim_dirty (victim_dirty),
      .upd          (cpu_upd),
      .nxt_st       (cpu_nst)
   );

   assign line_st    = seen;
   assign bus_addr   = cpu_addr;
   assign evict_wb   = victim_dirty;
   assign evict_addr = {tag_cpu_raw, c_idx};

   // Observation registers for the temporal checks below.
   logic              prv_xfill, prv_silent;
   logic [ADDR_W-1:0] prv_addr;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prv_xfill  <= 1'b0;
         prv_silent <= 1'b0;
         prv_addr   <= '0;
      end else begin
         prv_xfill  <= bus_rd_miss && fill_excl;
         prv_silent <= cpu_req && cpu_we && (line_st == 2'd2);
         prv_addr   <= cpu_addr;
      end
   end

   assert_excl_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prv_xfill && cpu_addr == prv_addr && !snp_rd && !snp_wr) |-> line_st == 2'd2);

   assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && line_st == 2'd2) |-> !bus_wr_miss && !bus_rd_miss);

   assert_upgrade_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prv_silent && cpu_addr == prv_addr && !snp_rd && !snp_wr) |-> line_st == 2'd3);

   assert_read_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hit && !cpu_we) |-> !bus_rd_miss && !bus_wr_miss && !evict_wb);

   assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_rd_miss, bus_wr_miss}));

   assert_evict_with_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
      evict_wb |-> (bus_rd_miss || bus_wr_miss) && !cpu_hit);

   assert_flush_needs_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_wb |-> (snp_rd || snp_wr));

endmodule

// File: tb/cex_snoop_ctrl_bench.sv
module cex_snoop_ctrl_bench;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0, fill_excl = 1'b0;
   logic          snp_rd = 1'b0, snp_wr = 1'b0;
   logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
   logic          cpu_hit, bus_rd_miss, bus_wr_miss, evict_wb, flush_wb;
   logic [1:0]    line_st;
   logic [AW-1:0] bus_addr, evict_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic          o_hit, o_rd, o_wr, o_ev, o_fl;
   logic [1:0]    o_st;
   logic [AW-1:0] o_ba, o_ea;

   localparam logic [AW-1:0] A = 16'h1203;
   localparam logic [AW-1:0] B = 16'h4503;
   localparam logic [AW-1:0] C = 16'h0005;

   always #5 clk = ~clk;

   cex_snoop_ctrl #(.LINES(8), .ADDR_W(AW)) u_cex_snoop_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .fill_excl(fill_excl), .snp_rd(snp_rd),
      .snp_wr(snp_wr), .snp_addr(snp_addr), .cpu_hit(cpu_hit),
      .line_st(line_st), .bus_rd_miss(bus_rd_miss), .bus_wr_miss(bus_wr_miss),
      .bus_addr(bus_addr), .evict_wb(evict_wb), .evict_addr(evict_addr),
      .flush_wb(flush_wb)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Drive one cycle of stimulus, capture outputs, let the edge commit.
   task automatic step(input logic req, input logic we, input logic [AW-1:0] a,
                       input logic xf, input logic srd, input logic swr,
                       input logic [AW-1:0] sa);
      cpu_req = req; cpu_we = we; cpu_addr = a; fill_excl = xf;
      snp_rd = srd; snp_wr = swr; snp_addr = sa;
      #1;
      o_hit = cpu_hit; o_st = line_st; o_rd = bus_rd_miss; o_wr = bus_wr_miss;
      o_ba = bus_addr; o_ev = evict_wb; o_ea = evict_addr; o_fl = flush_wb;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0; fill_excl = 1'b0;
      snp_rd = 1'b0; snp_wr = 1'b0;
   endtask

   task automatic peek(input logic [AW-1:0] a, output logic [1:0] st);
      cpu_req = 1'b0; cpu_addr = a;
      #1;
      st = line_st;
      check("R1", "hit without request", {31'd0, cpu_hit}, 32'd0);
   endtask

   task automatic t_reset();
      logic [1:0] s;
      peek(A, s); check("R1", "reset state A", {30'd0, s}, 32'd0);
      peek(C, s); check("R1", "reset state C", {30'd0, s}, 32'd0);
      peek(16'hFFFF, s); check("R1", "reset state top", {30'd0, s}, 32'd0);
   endtask

   task automatic t_excl_fill_and_hits();
      logic [1:0] s;
      step(1, 0, A, 1, 0, 0, '0);
      check("R2", "read miss request", {31'd0, o_rd}, 32'd1);
      check("R2", "read miss addr", {16'd0, o_ba}, {16'd0, A});
      check("R2", "read miss hit", {31'd0, o_hit}, 32'd0);
      check("R7", "no victim from invalid", {31'd0, o_ev}, 32'd0);
      peek(A, s); check("R2", "exclusive fill", {30'd0, s}, 32'd2);
      step(1, 0, A, 0, 0, 0, '0);
      check("R3", "read hit", {31'd0, o_hit}, 32'd1);
      check("R3", "read hit bus", {30'd0, o_rd, o_wr}, 32'd0);
      peek(A, s); check("R3", "clean stays clean", {30'd0, s}, 32'd2);
      step(1, 1, A, 0, 0, 0, '0);
      check("R4", "silent upgrade bus", {30'd0, o_rd, o_wr}, 32'd0);
      check("R4", "silent upgrade hit", {31'd0, o_hit}, 32'd1);
      peek(A, s); check("R4", "upgraded dirty", {30'd0, s}, 32'd3);
      step(1, 0, A, 0, 0, 0, '0);
      peek(A, s); check("R3", "dirty read hit keeps", {30'd0, s}, 32'd3);
   endtask

   task automatic t_snoop_dirty_read_then_write_hit();
      logic [1:0] s;
      step(0, 0, C, 0, 1, 0, A);
      check("R8", "flush on dirty read snoop", {31'd0, o_fl}, 32'd1);
      peek(A, s); check("R8", "dirty to shared", {30'd0, s}, 32'd1);
      step(0, 0, C, 0, 1, 0, A);
      check("R8", "shared no flush", {31'd0, o_fl}, 32'd0);
      peek(A, s); check("R8", "shared stays", {30'd0, s}, 32'd1);
      step(1, 1, A, 0, 0, 0, '0);
      check("R5", "shared write request", {30'd0, o_rd, o_wr}, 32'd1);
      check("R5", "shared write hit", {31'd0, o_hit}, 32'd1);
      peek(A, s); check("R5", "shared to dirty", {30'd0, s}, 32'd3);
   endtask

   task automatic t_victims();
      logic [1:0] s;
      step(1, 0, B, 1, 0, 0, '0);
      check("R7", "dirty victim strobe", {31'd0, o_ev}, 32'd1);
      check("R7", "dirty victim addr", {16'd0, o_ea}, {16'd0, A});
      check("R7", "with read request", {31'd0, o_rd}, 32'd1);
      peek(B, s); check("R2", "fill from dirty victim", {30'd0, s}, 32'd2);
      peek(A, s); check("R1", "tag mismatch reads 0", {30'd0, s}, 32'd0);
      step(1, 0, A, 0, 0, 0, '0);
      check("R7", "clean victim no strobe", {31'd0, o_ev}, 32'd0);
      check("R2", "shared fill request", {31'd0, o_rd}, 32'd1);
      peek(A, s); check("R2", "shared fill", {30'd0, s}, 32'd1);
      step(1, 1, B, 0, 0, 0, '0);
      check("R6", "write miss request", {30'd0, o_rd, o_wr}, 32'd1);
      check("R6", "write miss addr", {16'd0, o_ba}, {16'd0, B});
      check("R7", "shared victim no strobe", {31'd0, o_ev}, 32'd0);
      peek(B, s); check("R6", "write miss dirty", {30'd0, s}, 32'd3);
   endtask

   task automatic t_snoops_other();
      logic [1:0] s;
      step(0, 0, C, 0, 0, 1, A);
      check("R10", "mismatch no flush", {31'd0, o_fl}, 32'd0);
      peek(B, s); check("R10", "mismatch keeps dirty", {30'd0, s}, 32'd3);
      step(0, 0, A, 0, 1, 0, 16'h0006);
      check("R10", "invalid line no flush", {31'd0, o_fl}, 32'd0);
      peek(16'h0006, s); check("R10", "invalid stays", {30'd0, s}, 32'd0);
      step(1, 0, C, 1, 0, 0, '0);
      step(0, 0, A, 0, 1, 0, C);
      check("R8", "clean read snoop no flush", {31'd0, o_fl}, 32'd0);
      peek(C, s); check("R8", "clean to shared", {30'd0, s}, 32'd1);
      step(0, 0, A, 0, 0, 1, C);
      check("R9", "shared write snoop no flush", {31'd0, o_fl}, 32'd0);
      peek(C, s); check("R9", "shared invalidated", {30'd0, s}, 32'd0);
      step(1, 1, C, 0, 0, 0, '0);
      check("R6", "write miss from invalid", {31'd0, o_wr}, 32'd1);
      step(0, 0, A, 0, 0, 1, B);
      check("R9", "dirty write snoop flush", {31'd0, o_fl}, 32'd1);
      peek(B, s); check("R9", "dirty invalidated", {30'd0, s}, 32'd0);
   endtask

   task automatic t_same_cycle();
      logic [1:0] s;
      step(1, 0, A, 1, 0, 0, '0);
      peek(A, s); check("R2", "setup clean", {30'd0, s}, 32'd2);
      step(1, 0, A, 0, 0, 1, A);
      check("R11", "access sees invalid", {30'd0, o_st}, 32'd0);
      check("R11", "access misses", {31'd0, o_hit}, 32'd0);
      check("R11", "access requests", {31'd0, o_rd}, 32'd1);
      check("R12", "single request", {30'd0, o_rd, o_wr}, 32'd2);
      peek(A, s); check("R11", "refilled shared", {30'd0, s}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_excl_fill_and_hits();
      t_snoop_dirty_read_then_write_hit();
      t_victims();
      t_snoops_other();
      t_same_cycle();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule